// File: doc/BRIEF.md
# Page-Start Key Sequencer for Write Protection

This block sits beside the write controller of a byte-wide nonvolatile memory. It watches each accepted write load, a 13-bit address with 8-bit data, and spots fixed address/data key sequences at the start of a page load. It keeps a sticky protection mode. When the write controller signals a page commit, the block answers in the same cycle whether that page may go to the array.

There are three key sequences. The three-load *lock* sequence is 1555/AA, 0AAA/55, 1555/A0. The six-load *unlock* sequence is 1555/AA, 0AAA/55, 1555/80, 1555/AA, 0AAA/55, 1555/20. The six-load *erase* sequence matches unlock except that its last data byte is 0x10. Key loads are flagged as commands so that the page buffer drops them. Only the data loads that follow the keys are candidates for commit. A wrong key, or a key that arrives too late, aborts recognition, and that load counts as page data.

Top module: `swp_seq`

## Requirements
- R1: After reset, protection is off, `clr_req` is 0, and `is_cmd` and `commit_ok` are 0 while no load and no commit are presented.
- R2: While protection is off, a commit of a page holding at least one data load gives `commit_ok`=1 in the commit cycle. A commit of a page with no data load gives 0.
- R3: `is_cmd` is 1 in the same cycle as a load that matches the next expected key. Keys are recognised only before the first data load of a page. After a data load, a key-valued load is data and `is_cmd` stays 0.
- R4: Lock keys followed by data make that page's commit allowed and turn protection on. Later pages without leading keys are then refused (`commit_ok`=0).
- R5: While protection is on, a page that starts with the lock keys and holds data is allowed to commit.
- R6: Unlock keys followed by data make that page's commit allowed and turn protection off for later pages.
- R7: Unlock keys with no data before the commit leave protection unchanged.
- R8: Lock keys with no data before the commit do not protect the next data page, which commits. Protection turns on after that next data commit.
- R9: The erase sequence flags all six loads as commands and drives `clr_req` high for exactly one cycle, in the cycle after the sixth load. Protection is unchanged.
- R10: A load whose address or data differs from the expected key aborts the sequence. That load has `is_cmd`=0 and counts as page data, so a protected page that contains it is refused.
- R11: Each key after the first must arrive within `GAP_LIMIT` cycles of the previous key. A key presented `GAP_LIMIT`+1 or more cycles later is not recognised.
- R12: At the third key (address 0x1555), data 0xA0 completes the lock sequence and data 0x80 continues toward unlock or erase. Any other data aborts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | One accepted write load this cycle |
| ld_addr | input | 13 | Load address |
| ld_data | input | 8 | Load data |
| commit | input | 1 | Page-commit event from the write controller |
| commit_ok | output | 1 | Page may be written (valid in the commit cycle) |
| is_cmd | output | 1 | Current load is a key, not page data |
| clr_req | output | 1 | One-cycle whole-array erase request |

## Verification
`is_cmd` and `commit_ok` are combinational, so the bench drives a load or a commit just after a falling edge and samples 1 ns later in that same cycle. `clr_req` is registered, so it is due exactly one cycle after the sixth erase key. The bench reads it at the next falling edge and once more a cycle later to confirm the single pulse. Protection changes are checked only through the `commit_ok` of later pages. The gap limit is checked at exactly `GAP_LIMIT` and `GAP_LIMIT`+1 cycles between keys, and a corrupted key is swept across every sequence position.

// File: rtl/swp_pkg.sv
package swp_pkg;
  localparam int KEY_AW = 13;
  localparam int KEY_DW = 8;
  localparam logic [KEY_AW-1:0] KA_HI = 13'h1555;
  localparam logic [KEY_AW-1:0] KA_LO = 13'h0AAA;

  typedef enum logic [1:0] {PG_PLAIN, PG_LOCK, PG_UNLOCK} pg_key_e;

  // expected key address for a step (0..5)
  function automatic logic [KEY_AW-1:0] key_addr(input logic [2:0] step);
    return (step == 3'd1 || step == 3'd4) ? KA_LO : KA_HI;
  endfunction

  // primary expected key data for a step
  function automatic logic [KEY_DW-1:0] key_data(input logic [2:0] step);
    case (step)
      3'd0, 3'd3: return 8'hAA;
      3'd1, 3'd4: return 8'h55;
      3'd2:       return 8'h80;
      default:    return 8'h20;
    endcase
  endfunction

  // alternate data accepted at branching steps
  function automatic logic [KEY_DW-1:0] key_alt(input logic [2:0] step);
    case (step)
      3'd2:    return 8'hA0;
      3'd5:    return 8'h10;
      default: return key_data(step);
    endcase
  endfunction
endpackage

// File: rtl/swp_keymatch.sv
module swp_keymatch
  import swp_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic [2:0]        step,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic              hit,
  output logic              fin_lock,
  output logic              fin_unlock,
  output logic              fin_clear
);
  logic a_ok, d_pri, d_alt;

  always_comb begin
    a_ok       = (addr == ADDR_W'(key_addr(step)));
    d_pri      = (data == DATA_W'(key_data(step)));
    d_alt      = (data == DATA_W'(key_alt(step)));
    hit        = a_ok && (d_pri || d_alt);
    fin_lock   = hit && (step == 3'd2) && d_alt;
    fin_unlock = hit && (step == 3'd5) && d_pri;
    fin_clear  = hit && (step == 3'd5) && d_alt;
  end

  always_comb begin
    AST_FINISH_EXCLUSIVE: assert ($countones({fin_lock, fin_unlock, fin_clear}) <= 1); // R12
  end
endmodule

// File: rtl/swp_gap_timer.sv
module swp_gap_timer #(
  parameter int GAP_LIMIT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic kick,
  output logic expire
);
  localparam int CW = $clog2(GAP_LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(GAP_LIMIT - 1);

  logic [CW-1:0] cnt;

  assign expire = run && !kick && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt <= '0;
    else if (kick || !run)   cnt <= '0;
    else if (cnt == LAST)    cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end

  AST_GAP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(GAP_LIMIT)); // R11
  AST_EXPIRE_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (cnt == '0)); // R11
endmodule

// File: rtl/swp_seq.sv
module swp_seq
  import swp_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int DATA_W    = 8,
  parameter int GAP_LIMIT = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              commit,
  output logic              commit_ok,
  output logic              is_cmd,
  output logic              clr_req
);
  localparam logic [2:0] LAST_STEP = 3'd5;

  logic [2:0] step_q;
  logic       has_data_q, prot_q, arm_q, clr_q;
  pg_key_e    keyed_q;

  logic hit, fin_lock, fin_unlock, fin_clear;
  logic key_load, data_load, expire;

  swp_keymatch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) match_i (
    .step(step_q), .addr(ld_addr), .data(ld_data),
    .hit(hit), .fin_lock(fin_lock), .fin_unlock(fin_unlock), .fin_clear(fin_clear)
  );

  swp_gap_timer #(.GAP_LIMIT(GAP_LIMIT)) gap_i (
    .clk(clk), .rst_n(rst_n), .run(step_q != 3'd0),
    .kick(ld_valid || commit), .expire(expire)
  );

  // named events
  assign key_load  = ld_valid && !commit && hit && !has_data_q && (keyed_q == PG_PLAIN);
  assign data_load = ld_valid && !commit && !key_load;

  assign is_cmd    = key_load;
  assign clr_req   = clr_q;
  assign commit_ok = commit && has_data_q && (!prot_q || keyed_q != PG_PLAIN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_q <= '0; has_data_q <= 1'b0; keyed_q <= PG_PLAIN;
      prot_q <= 1'b0; arm_q <= 1'b0; clr_q <= 1'b0;
    end else begin
      clr_q <= 1'b0;
      if (commit) begin
        step_q <= '0; has_data_q <= 1'b0; keyed_q <= PG_PLAIN;
        if (has_data_q) begin
          arm_q <= 1'b0;
          if (keyed_q == PG_UNLOCK)                prot_q <= 1'b0;
          else if (keyed_q == PG_LOCK || arm_q)    prot_q <= 1'b1;
        end else if (keyed_q == PG_LOCK) begin
          arm_q <= 1'b1;
        end
      end else if (key_load) begin
        if (fin_lock) begin
          keyed_q <= PG_LOCK;   step_q <= '0;
        end else if (fin_unlock) begin
          keyed_q <= PG_UNLOCK; step_q <= '0;
        end else if (fin_clear) begin
          clr_q <= 1'b1;        step_q <= '0;
        end else begin
          step_q <= step_q + 3'd1;
        end
      end else if (data_load) begin
        has_data_q <= 1'b1; step_q <= '0;
      end else if (expire) begin
        step_q <= '0;
      end
    end
  end

  AST_STEP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    step_q <= LAST_STEP); // R10
  AST_CLR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req |=> !clr_req); // R9
  AST_CLR_FROM_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req |-> $past(is_cmd)); // R9
  AST_DATA_BLOCKS_KEYS: assert property (@(posedge clk) disable iff (!rst_n)
    (data_load && !commit) |=> !is_cmd); // R3
  AST_PROT_AT_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_q != $past(prot_q)) |-> $past(commit)); // R4
  AST_CLR_KEEPS_PROT: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req |-> $stable(prot_q)); // R9
endmodule

// File: tb/swp_seq_tb.sv
module swp_seq_tb_top;
  localparam int GL = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ld_valid = 1'b0, commit = 1'b0;
  logic [12:0] ld_addr = '0;
  logic [7:0]  ld_data = '0;
  logic commit_ok, is_cmd, clr_req;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  swp_seq #(.ADDR_W(13), .DATA_W(8), .GAP_LIMIT(GL)) dut_i (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_addr(ld_addr),
    .ld_data(ld_data), .commit(commit), .commit_ok(commit_ok),
    .is_cmd(is_cmd), .clr_req(clr_req)
  );

  task automatic chk(input bit got, input bit exp, input string req);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, got, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ld_valid = 1'b0; commit = 1'b0;
    end
  endtask

  task automatic load(input logic [12:0] a, input logic [7:0] d, input bit exp_cmd, input string req);
    @(negedge clk); commit = 1'b0; ld_valid = 1'b1; ld_addr = a; ld_data = d;
    #1 chk(is_cmd, exp_cmd, req);
  endtask

  task automatic do_commit(input bit exp_ok, input string req);
    @(negedge clk); ld_valid = 1'b0; commit = 1'b1;
    #1 chk(commit_ok, exp_ok, req);
  endtask

  task automatic lock_keys(input string req);
    load(13'h1555, 8'hAA, 1, req);
    load(13'h0AAA, 8'h55, 1, req);
    load(13'h1555, 8'hA0, 1, req);
  endtask

  task automatic six_keys(input logic [7:0] last, input string req);
    load(13'h1555, 8'hAA, 1, req);
    load(13'h0AAA, 8'h55, 1, req);
    load(13'h1555, 8'h80, 1, req);
    load(13'h1555, 8'hAA, 1, req);
    load(13'h0AAA, 8'h55, 1, req);
    load(13'h1555, last, 1, req);
  endtask

  task automatic plain_page(input bit exp_ok, input string req);
    load(13'h0040, 8'h3C, 0, req);
    load(13'h0041, 8'hC3, 0, req);
    do_commit(exp_ok, req);
  endtask

  initial begin
    #400000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [12:0] ka [6];
    logic [7:0]  kd [6];
    ka = '{13'h1555, 13'h0AAA, 13'h1555, 13'h1555, 13'h0AAA, 13'h1555};
    kd = '{8'hAA, 8'h55, 8'h80, 8'hAA, 8'h55, 8'h20};
    idle(3);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk(clr_req, 0, "R1 clr");
    chk(is_cmd, 0, "R1 cmd");
    chk(commit_ok, 0, "R1 ok");

    // R2 unprotected
    plain_page(1, "R2 data page");
    do_commit(0, "R2 empty page");

    // R4 lock with data, R12 A0 branch
    lock_keys("R12 lock keys");
    load(13'h0100, 8'h11, 0, "R4 data");
    do_commit(1, "R4 locking page");
    plain_page(0, "R4 refused");

    // R5 keyed page while protected
    lock_keys("R5 keys");
    load(13'h0200, 8'h22, 0, "R5 data");
    do_commit(1, "R5 keyed");

    // R3 keys after data are data
    load(13'h0001, 8'h99, 0, "R3 data first");
    load(13'h1555, 8'hAA, 0, "R3 late key");
    do_commit(0, "R3 unkeyed refused");

    // R10 mismatch sweep over every position
    for (int pos = 0; pos < 6; pos++) begin
      for (int k = 0; k < pos; k++) load(ka[k], kd[k], 1, "R10 prefix");
      load(ka[pos], kd[pos] ^ 8'h01, 0, "R10 bad data");
      do_commit(0, "R10 aborted page");
      idle(1);
      chk(clr_req, 0, "R10 no clear");
    end
    load(13'h1554, 8'hAA, 0, "R10 bad addr");
    do_commit(0, "R10 bad addr page");

    // R11 gap limit
    load(13'h1555, 8'hAA, 1, "R11 k1");
    idle(GL - 1);
    load(13'h0AAA, 8'h55, 1, "R11 within limit");
    idle(GL);
    load(13'h1555, 8'hA0, 0, "R11 too late");
    do_commit(0, "R11 page");

    // R7 unlock without data
    six_keys(8'h20, "R7 keys");
    do_commit(0, "R7 empty");
    plain_page(0, "R7 still protected");

    // R6 unlock with data, R12 80 branch
    six_keys(8'h20, "R12 unlock keys");
    load(13'h0300, 8'h33, 0, "R6 data");
    do_commit(1, "R6 unlocking page");
    plain_page(1, "R6 unprotected");

    // R8 lock without data
    lock_keys("R8 keys");
    do_commit(0, "R8 empty");
    plain_page(1, "R8 next page unprotected");
    plain_page(0, "R8 protected after");

    // R9 erase
    six_keys(8'h10, "R9 keys");
    idle(1);
    chk(clr_req, 1, "R9 pulse");
    idle(1);
    chk(clr_req, 0, "R9 single");
    plain_page(0, "R9 protection kept");
    six_keys(8'h20, "R9 unlock");
    load(13'h0400, 8'h44, 0, "R9 data");
    do_commit(1, "R9 unlock page");

    idle(2);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule